// File: doc/BRIEF.md
# GPIO pin multiplexing controller

This block holds the per-pin configuration of a general-purpose I/O port of `WIDTH` pins (32 by default) and computes what each pad drives. For every pin it keeps five state bits: pull-up off, owned-by-GPIO, peripheral-B-selected, GPIO output enable and GPIO output data. Each bit group is changed through a write-one-to-set address and a write-one-to-clear address, and it is read back through a status address. Software uses a single synchronous bus to change the configuration. The write takes effect at the clock edge, and reads are combinational from the address.

A pin owned by the GPIO logic drives its data bit whenever its output-enable bit is set. A pin handed to a peripheral takes its value and its enable from peripheral A or from peripheral B, as the A/B bit selects. Only the output path is steered. The pad input always reaches both peripherals. Pins that have no peripheral behind them are marked by `PERIPH_MASK`, and they stay under GPIO control for good. The reset ownership of each pin comes from `OWN_RESET`, so chosen pins can come up already driven by a peripheral.

Top module: `gpio_pinmux`

## Requirements
- R1: Pull-up state: a write to address 6 sets the status bits under the ones of the data word (pull-up off), and a write to address 7 clears them (pull-up on). Address 8 reads the status, and `pullup_en` is its bitwise inverse. The status resets to all zeros, and writes work whatever the pin's other configuration is.
- R2: Ownership: a write to address 0 sets the ownership status bits (1 = GPIO owns the pin), and a write to address 1 clears them (0 = peripheral owns it). Address 2 reads the status. For multiplexed pins the status resets to `OWN_RESET`.
- R3: For pins whose `PERIPH_MASK` bit is 0, writes to addresses 0 and 1 have no effect, the ownership status always reads 1, and the pin always behaves as GPIO-owned.
- R4: A/B selection: a write to address 10 sets the status bits (1 = peripheral B), and a write to address 9 clears them (0 = peripheral A). Address 11 reads the status. It resets to all zeros, and writes work whatever the pin's ownership is.
- R5: On a peripheral-owned pin, `pin_out` and `pin_oe` equal `pa_out`/`pa_oe` when the A/B bit is 0, and `pb_out`/`pb_oe` when it is 1.
- R6: On a GPIO-owned pin, `pin_oe` equals the output-enable status and `pin_out` equals the data status. Output enable is set at address 3, cleared at address 4 and read at address 5. Data is set at address 12, cleared at address 13 and read at address 14. Both reset to zero.
- R7: `pa_in` and `pb_in` always equal `pin_in`, whatever the configuration. Address 15 reads `pin_in`.
- R8: Set and clear addresses read as 0. In every status register, bits where the written word holds 0 keep their value.
- R9: When a set write and a clear write hit the same bit in successive cycles, the later write decides the bit's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW | Register address for writes and reads |
| bus_wdata | input | WIDTH | Write data, one bit per pin |
| bus_rdata | output | WIDTH | Read data for `bus_addr` |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad drive enables |
| pullup_en | output | WIDTH | Pull-up enables, 1 = on |
| pa_out | input | WIDTH | Peripheral A output values |
| pa_oe | input | WIDTH | Peripheral A drive enables |
| pb_out | input | WIDTH | Peripheral B output values |
| pb_oe | input | WIDTH | Peripheral B drive enables |
| pa_in | output | WIDTH | Pad input forwarded to peripheral A |
| pb_in | output | WIDTH | Pad input forwarded to peripheral B |

## Verification
The peripheral A and B drive pairs use complementary bit patterns (0xAA against 0x55, and 0xF0 against 0x0F). Because of this, each output bit shows which source was picked, and a crossed A/B select or a wrong owner changes the value. The output mux is then tried again with mixed configurations: some pins GPIO-owned with enables, some on A and some on B, and some non-multiplexed pins given ownership writes. This separates the selector paths from the `PERIPH_MASK` override. Set and clear words touch only some bits, so the checks can see that bits outside the word keep their value. A bit that is set and then cleared, and then set again, shows that the later write wins.

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int WIDTH = 32,
  parameter int AW = 4,
  parameter logic [WIDTH-1:0] PERIPH_MASK = 32'h0FFF_FFFF,
  parameter logic [WIDTH-1:0] OWN_RESET = 32'hFFFF_FF00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pullup_en,
  input  logic [WIDTH-1:0] pa_out,
  input  logic [WIDTH-1:0] pa_oe,
  input  logic [WIDTH-1:0] pb_out,
  input  logic [WIDTH-1:0] pb_oe,
  output logic [WIDTH-1:0] pa_in,
  output logic [WIDTH-1:0] pb_in
);

  localparam logic [WIDTH-1:0] NOMUX = ~PERIPH_MASK;
  localparam logic [WIDTH-1:0] OWN_INIT = OWN_RESET | NOMUX;

  localparam logic [AW-1:0] A_OWN_SET = AW'(0);
  localparam logic [AW-1:0] A_OWN_CLR = AW'(1);
  localparam logic [AW-1:0] A_OWN_ST  = AW'(2);
  localparam logic [AW-1:0] A_OE_SET  = AW'(3);
  localparam logic [AW-1:0] A_OE_CLR  = AW'(4);
  localparam logic [AW-1:0] A_OE_ST   = AW'(5);
  localparam logic [AW-1:0] A_PU_OFF  = AW'(6);
  localparam logic [AW-1:0] A_PU_ON   = AW'(7);
  localparam logic [AW-1:0] A_PU_ST   = AW'(8);
  localparam logic [AW-1:0] A_SEL_A   = AW'(9);
  localparam logic [AW-1:0] A_SEL_B   = AW'(10);
  localparam logic [AW-1:0] A_AB_ST   = AW'(11);
  localparam logic [AW-1:0] A_DO_SET  = AW'(12);
  localparam logic [AW-1:0] A_DO_CLR  = AW'(13);
  localparam logic [AW-1:0] A_DO_ST   = AW'(14);
  localparam logic [AW-1:0] A_PIN     = AW'(15);

  logic [WIDTH-1:0] own_q, oe_q, pu_q, ab_q, do_q;
  logic [WIDTH-1:0] per_out, per_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= OWN_INIT;
      oe_q  <= '0;
      pu_q  <= '0;
      ab_q  <= '0;
      do_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OWN_SET: own_q <= own_q | bus_wdata;
        A_OWN_CLR: own_q <= own_q & ~(bus_wdata & PERIPH_MASK);
        A_OE_SET:  oe_q  <= oe_q | bus_wdata;
        A_OE_CLR:  oe_q  <= oe_q & ~bus_wdata;
        A_PU_OFF:  pu_q  <= pu_q | bus_wdata;
        A_PU_ON:   pu_q  <= pu_q & ~bus_wdata;
        A_SEL_B:   ab_q  <= ab_q | bus_wdata;
        A_SEL_A:   ab_q  <= ab_q & ~bus_wdata;
        A_DO_SET:  do_q  <= do_q | bus_wdata;
        A_DO_CLR:  do_q  <= do_q & ~bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_OWN_ST: bus_rdata = own_q;
      A_OE_ST:  bus_rdata = oe_q;
      A_PU_ST:  bus_rdata = pu_q;
      A_AB_ST:  bus_rdata = ab_q;
      A_DO_ST:  bus_rdata = do_q;
      A_PIN:    bus_rdata = pin_in;
      default:  bus_rdata = '0;
    endcase
  end

  assign per_out   = (ab_q & pb_out) | (~ab_q & pa_out);
  assign per_oe    = (ab_q & pb_oe)  | (~ab_q & pa_oe);
  assign pin_out   = (own_q & do_q) | (~own_q & per_out);
  assign pin_oe    = (own_q & oe_q) | (~own_q & per_oe);
  assign pullup_en = ~pu_q;
  assign pa_in     = pin_in;
  assign pb_in     = pin_in;

  AST_PU_OFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PU_OFF) |=> ((pullup_en & $past(bus_wdata)) == '0)); // R1

  AST_OWN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OWN_SET) |=> ((own_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_NOMUX_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & NOMUX) == (oe_q & NOMUX)) && ((pin_out & NOMUX) == (do_q & NOMUX))); // R3

  AST_SELA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SEL_A) |=> ((ab_q & $past(bus_wdata)) == '0)); // R4

  AST_OE_KEEPS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OE_SET) |=> ((oe_q & ~$past(bus_wdata)) == ($past(oe_q) & ~$past(bus_wdata)))); // R8

endmodule

// File: tb/gpio_pinmux_test.sv
module gpio_pinmux_test;
  localparam int W = 32;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, pin_out, pin_oe, pullup_en, pa_in, pb_in;
  logic [W-1:0] pin_in = '0, pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int kq[$];
  logic [W-1:0] eq[$];
  string tq[$];

  always #5 clk = ~clk;

  gpio_pinmux uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pullup_en(pullup_en),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pa_in(pa_in), .pb_in(pb_in)
  );

  // kinds: 0 rdata, 1 pin_out, 2 pin_oe, 3 pullup_en, 4 pa_in, 5 pb_in
  always @(negedge clk) begin
    while (kq.size() > 0) begin
      int k;
      logic [W-1:0] e, a;
      string t;
      k = kq.pop_front();
      e = eq.pop_front();
      t = tq.pop_front();
      case (k)
        0: a = bus_rdata;
        1: a = pin_out;
        2: a = pin_oe;
        3: a = pullup_en;
        4: a = pa_in;
        default: a = pb_in;
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [W-1:0] e, input string t);
    bus_addr = a;
    kq.push_back(0); eq.push_back(e); tq.push_back(t);
    @(posedge clk); #1;
  endtask

  task automatic expect_port(input int k, input logic [W-1:0] e, input string t);
    kq.push_back(k); eq.push_back(e); tq.push_back(t);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    pa_oe = 32'h0000_00AA; pa_out = 32'h0000_00F0;
    pb_oe = 32'h0000_0055; pb_out = 32'h0000_000F;

    expect_rd(2, 32'hFFFF_FF00, "R2 reset ownership");
    expect_rd(8, 32'h0, "R1 reset pull-up status");
    expect_port(3, 32'hFFFF_FFFF, "R1 reset pull-ups on");
    expect_rd(11, 32'h0, "R4 reset A/B status");
    expect_rd(5, 32'h0, "R6 reset output enable");
    expect_rd(14, 32'h0, "R6 reset data");
    expect_port(2, 32'h0000_00AA, "R5 peripheral A enables");
    expect_port(1, 32'h0000_00F0, "R5 peripheral A values");

    wr(10, 32'h0000_000F);
    expect_rd(11, 32'h0000_000F, "R4 select B");
    expect_port(2, 32'h0000_00A5, "R5 mixed A/B enables");
    expect_port(1, 32'h0000_00FF, "R5 mixed A/B values");
    expect_rd(10, 32'h0, "R8 set address reads zero");

    wr(10, 32'h0010_0000);
    expect_rd(11, 32'h0010_000F, "R4 select on GPIO-owned pin");
    wr(9, 32'h0000_0003);
    expect_rd(11, 32'h0010_000C, "R4 select A keeps other bits");

    wr(0, 32'hFFFF_FFFF);
    expect_rd(2, 32'hFFFF_FFFF, "R2 GPIO enable");
    wr(1, 32'hF000_00FF);
    expect_rd(2, 32'hFFFF_FF00, "R3 non-mux pins stay GPIO");
    wr(1, 32'h0000_0F00);
    expect_rd(2, 32'hFFFF_F000, "R2 GPIO disable");
    expect_rd(1, 32'h0, "R8 clear address reads zero");

    wr(3, 32'h000F_0000);
    wr(12, 32'h0005_0000);
    expect_port(2, 32'h000F_00A6, "R6 GPIO enables with peripheral mix");
    expect_port(1, 32'h0005_00FC, "R6 GPIO data with peripheral mix");
    wr(4, 32'h0001_0000);
    expect_rd(5, 32'h000E_0000, "R8 output disable keeps other bits");

    wr(3, 32'h3000_0000);
    wr(12, 32'h1000_0000);
    expect_port(2, 32'h300E_00A6, "R3 non-mux pin drives GPIO");
    expect_port(1, 32'h1005_00FC, "R3 non-mux pin GPIO data");

    wr(6, 32'h8000_0001);
    expect_rd(8, 32'h8000_0001, "R1 pull-up off");
    expect_port(3, 32'h7FFF_FFFE, "R1 pull-up enable output");
    wr(7, 32'h0000_0001);
    expect_port(3, 32'h7FFF_FFFF, "R1 pull-up back on");

    wr(12, 32'h0000_0100);
    wr(13, 32'h0000_0100);
    expect_rd(14, 32'h1005_0000, "R9 later clear wins");
    wr(12, 32'h0000_0100);
    expect_rd(14, 32'h1005_0100, "R9 later set wins");

    pin_in = 32'h1234_5678;
    expect_port(4, 32'h1234_5678, "R7 input to peripheral A");
    expect_port(5, 32'h1234_5678, "R7 input to peripheral B");
    expect_rd(15, 32'h1234_5678, "R7 pin input readback");
    wr(0, 32'hFFFF_FFFF);
    pin_in = 32'hCAFE_0001;
    expect_port(4, 32'hCAFE_0001, "R7 input under GPIO ownership");

    @(posedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule